// File: doc/BRIEF.md
# Interrupt Priority Register Bank

This block holds the priority level of every interrupt source and the priority threshold of every interrupt target (context) for a platform interrupt controller. Software reaches it through a plain register port: an address, 32-bit write data and a write enable, with read data returned combinationally for whatever address is presented. Every stored level is brought out on flat vectors so that the downstream selection logic can compare levels without going through the bus, and a one-cycle strobe tells that logic to re-evaluate after each accepted write.

Stored values are always legal. The parameter `MAX_PRIO` fixes the top level. When `MAX_PRIO+1` is a power of two, every write is accepted and reduced modulo `MAX_PRIO+1`: the high bits are simply discarded, so each stored bit reads back only if it is implemented. For any other `MAX_PRIO` a write above the top level is dropped and the register keeps its previous value. Thresholds obey the same rule as source priorities.

Source priorities are 32-bit words placed from `PRIO_BASE` at a 4-byte pitch; contexts occupy regions of `CTX_STRIDE` bytes (a power of two) from `CTX_BASE`, with the threshold in the first word of each region.

Top module: `prio_regbank`

## Requirements
- R1: While and after reset, every source priority, every threshold, the strobe and all read data are zero.
- R2: The word at byte address `PRIO_BASE + 4*k` (k from 0 to N_SRC-1) holds the priority of source k+1; reading it returns the stored value zero-extended to 32 bits. Address bits [1:0] are ignored everywhere.
- R3: When `MAX_PRIO+1` is a power of two, every write to a priority or threshold word is accepted and stores the written value modulo `MAX_PRIO+1`.
- R4: When `MAX_PRIO+1` is not a power of two, a written value no greater than `MAX_PRIO` is stored, and a larger value leaves the register unchanged.
- R5: The threshold of context c sits at byte address `CTX_BASE + c*CTX_STRIDE`; the context is selected by the address bits above the stride, the word within the region by the address masked with `CTX_STRIDE-1`, and only word 0 holds a register. Thresholds legalize as in R3 and R4.
- R6: `upd_strobe` is high for exactly the one cycle following each accepted priority or threshold write, and low otherwise.
- R7: Reads of any address without a register return zero, and writes to such addresses change no stored value and raise no strobe.
- R8: `src_prio_flat[(s-1)*PW +: PW]` carries the priority of source s and `ctx_thr_flat[c*PW +: PW]` the threshold of context c, where PW = clog2(MAX_PRIO+1).
- R9: A write takes effect at the clock edge that samples it; from then on the flat outputs and the read data show the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write enable, sampled at the rising edge |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| src_prio_flat | output | N_SRC*PW | Stored priorities, source 1 in the lowest field |
| ctx_thr_flat | output | N_CTX*PW | Stored thresholds, context 0 in the lowest field |
| upd_strobe | output | 1 | One-cycle pulse after each accepted write |

## Verification
Stored values, flat outputs and the strobe all change at the rising edge that samples a write, so the bench drives each write on a falling edge and samples the strobe and both flat vectors on the following falling edge, one register stage later. Read data has no register in its path; the bench presents an address on a falling edge and compares the read data a quarter period later, before the next rising edge. Two instances, one with eight levels and one with six, see identical bus traffic, so the same out-of-range write is seen reduced in the first and discarded in the second.

// File: rtl/prio_pkg.sv
package prio_pkg;
  // Width needed to hold levels 0..max_prio
  function automatic int level_width(input int max_prio);
    return (max_prio < 1) ? 1 : $clog2(max_prio + 1);
  endfunction

  // True when the level count is a power of two
  function automatic bit level_count_pow2(input int max_prio);
    return ((max_prio + 1) & max_prio) == 0;
  endfunction
endpackage

// File: rtl/prio_legal.sv
module prio_legal #(
  parameter int MAX_PRIO = 7,
  parameter int PW       = prio_pkg::level_width(MAX_PRIO)
) (
  input  logic [31:0]   wdata,
  output logic          ok,
  output logic [PW-1:0] val
);
  localparam bit POW2 = prio_pkg::level_count_pow2(MAX_PRIO);

  generate
    if (POW2) begin : g_wrap
      // modulo a power of two keeps the implemented low bits
      logic unused_hi;
      assign unused_hi = ^wdata[31:PW];
      assign ok  = 1'b1;
      assign val = wdata[PW-1:0];
    end else begin : g_drop
      assign ok  = (wdata <= 32'(MAX_PRIO));
      assign val = wdata[PW-1:0];
    end
  endgenerate
endmodule

// File: rtl/prio_addr_dec.sv
module prio_addr_dec #(
  parameter int ADDR_W     = 16,
  parameter int N_SRC      = 8,
  parameter int N_CTX      = 3,
  parameter int PRIO_BASE  = 'h0004,
  parameter int CTX_BASE   = 'h0200,
  parameter int CTX_STRIDE = 'h0080
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [N_SRC-1:0]  src_sel,
  output logic [N_CTX-1:0]  ctx_sel
);
  localparam int SLOG = $clog2(CTX_STRIDE);

  logic [31:0] a_word;
  logic [31:0] p_off;
  logic [31:0] c_off;
  logic        in_prio;
  logic        in_ctx;
  logic        word0;
  logic        unused_lo;

  always_comb begin
    a_word  = {{(32-ADDR_W){1'b0}}, addr[ADDR_W-1:2], 2'b00};
    p_off   = a_word - 32'(PRIO_BASE);
    c_off   = a_word - 32'(CTX_BASE);
    in_prio = (a_word >= 32'(PRIO_BASE)) && (p_off < 32'(4 * N_SRC));
    in_ctx  = (a_word >= 32'(CTX_BASE)) && (c_off < 32'(N_CTX * CTX_STRIDE));
    word0   = (c_off & 32'(CTX_STRIDE - 1)) == 32'd0;
  end
  assign unused_lo = ^addr[1:0];

  generate
    for (genvar i = 0; i < N_SRC; i++) begin : g_src
      assign src_sel[i] = in_prio && ((p_off >> 2) == 32'(i));
    end
    for (genvar c = 0; c < N_CTX; c++) begin : g_ctx
      assign ctx_sel[c] = in_ctx && word0 && ((c_off >> SLOG) == 32'(c));
    end
  endgenerate
endmodule

// File: rtl/prio_regbank.sv
module prio_regbank #(
  parameter int ADDR_W     = 16,
  parameter int N_SRC      = 8,
  parameter int N_CTX      = 3,
  parameter int MAX_PRIO   = 7,
  parameter int PRIO_BASE  = 'h0004,
  parameter int CTX_BASE   = 'h0200,
  parameter int CTX_STRIDE = 'h0080,
  parameter int PW         = prio_pkg::level_width(MAX_PRIO)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  input  logic                bus_we,
  output logic [31:0]         bus_rdata,
  output logic [N_SRC*PW-1:0] src_prio_flat,
  output logic [N_CTX*PW-1:0] ctx_thr_flat,
  output logic                upd_strobe
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [N_SRC-1:0] src_sel;
  logic [N_CTX-1:0] ctx_sel;
  logic             leg_ok;
  logic [PW-1:0]    leg_val;

  prio_addr_dec #(
    .ADDR_W(ADDR_W), .N_SRC(N_SRC), .N_CTX(N_CTX),
    .PRIO_BASE(PRIO_BASE), .CTX_BASE(CTX_BASE), .CTX_STRIDE(CTX_STRIDE)
  ) u_dec (
    .addr(bus_addr), .src_sel(src_sel), .ctx_sel(ctx_sel)
  );

  prio_legal #(.MAX_PRIO(MAX_PRIO), .PW(PW)) u_legal (
    .wdata(bus_wdata), .ok(leg_ok), .val(leg_val)
  );

  logic [PW-1:0] src_q [N_SRC];
  logic [PW-1:0] ctx_q [N_CTX];
  logic [N_SRC-1:0] src_en;
  logic [N_CTX-1:0] ctx_en;
  logic             strobe_d;
  logic             strobe_q;

  // next-state: per-register clock enables
  always_comb begin
    src_en   = src_sel & {N_SRC{bus_we & leg_ok}};
    ctx_en   = ctx_sel & {N_CTX{bus_we & leg_ok}};
    strobe_d = (|src_en) | (|ctx_en);
  end

  generate
    for (genvar i = 0; i < N_SRC; i++) begin : g_src_reg
      always_ff @(posedge clk or negedge rst_int_n) begin
        if (!rst_int_n)     src_q[i] <= '0;
        else if (src_en[i]) src_q[i] <= leg_val;
      end
      assign src_prio_flat[i*PW +: PW] = src_q[i];
    end
    for (genvar c = 0; c < N_CTX; c++) begin : g_ctx_reg
      always_ff @(posedge clk or negedge rst_int_n) begin
        if (!rst_int_n)     ctx_q[c] <= '0;
        else if (ctx_en[c]) ctx_q[c] <= leg_val;
      end
      assign ctx_thr_flat[c*PW +: PW] = ctx_q[c];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) strobe_q <= 1'b0;
    else            strobe_q <= strobe_d;
  end
  assign upd_strobe = strobe_q;

  // readback: selects are one-hot or empty, so an OR-reduce suffices
  always_comb begin
    logic [PW-1:0] acc;
    acc = '0;
    for (int i = 0; i < N_SRC; i++) if (src_sel[i]) acc = acc | src_q[i];
    for (int c = 0; c < N_CTX; c++) if (ctx_sel[c]) acc = acc | ctx_q[c];
    bus_rdata = {{(32-PW){1'b0}}, acc};
  end
endmodule

// File: rtl/prio_regbank_chk.sv
module prio_regbank_chk #(
  parameter int N_SRC    = 8,
  parameter int N_CTX    = 3,
  parameter int MAX_PRIO = 7,
  parameter int PW       = prio_pkg::level_width(MAX_PRIO)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_we,
  input logic [31:0]         bus_rdata,
  input logic [N_SRC*PW-1:0] src_prio_flat,
  input logic [N_CTX*PW-1:0] ctx_thr_flat,
  input logic                upd_strobe
);
  // R6: no strobe unless a write was sampled on the previous edge
  assert_strobe_needs_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> !upd_strobe);

  // R7/R9: with no write, no stored level moves
  assert_hold_without_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> ($stable(src_prio_flat) && $stable(ctx_thr_flat)));

  // R6: any change of a stored level comes with the strobe
  assert_change_strobes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(src_prio_flat) || !$stable(ctx_thr_flat)) |-> upd_strobe);

  // R1: reset clears all outputs
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (src_prio_flat == '0 && ctx_thr_flat == '0 && !upd_strobe));

  // R2: read data is zero-extended
  always_comb begin
    if (rst_n && PW < 32)
      assert_rdata_zero_ext_R2: assert (bus_rdata >> PW == 32'd0);
  end

  // R4: every stored field stays within MAX_PRIO
  always_comb begin
    if (rst_n) begin
      for (int i = 0; i < N_SRC; i++)
        assert_src_legal_R4: assert (32'(src_prio_flat[i*PW +: PW]) <= 32'(MAX_PRIO));
      for (int c = 0; c < N_CTX; c++)
        assert_thr_legal_R5: assert (32'(ctx_thr_flat[c*PW +: PW]) <= 32'(MAX_PRIO));
    end
  end
endmodule

bind prio_regbank prio_regbank_chk #(
  .N_SRC(N_SRC), .N_CTX(N_CTX), .MAX_PRIO(MAX_PRIO), .PW(PW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_rdata(bus_rdata),
  .src_prio_flat(src_prio_flat), .ctx_thr_flat(ctx_thr_flat),
  .upd_strobe(upd_strobe)
);

// File: tb/test_prio_regbank.sv
`timescale 1ns/1ps
module test_prio_regbank;
  localparam int AW = 16, NS = 8, NC = 3, PW = 3;
  localparam int PB = 'h0004, CB = 'h0200, CS = 'h0080;

  logic clk = 1'b0;
  logic rst_n;
  logic [AW-1:0] bus_addr;
  logic [31:0]   bus_wdata;
  logic          bus_we;
  logic [31:0]   rd_a, rd_b;
  logic [NS*PW-1:0] sp_a, sp_b;
  logic [NC*PW-1:0] ct_a, ct_b;
  logic          st_a, st_b;

  int n_cmp = 0, n_bad = 0;
  int m_src_a [NS+1], m_src_b [NS+1];
  int m_ctx_a [NC],   m_ctx_b [NC];

  always #10 clk = ~clk;  // 50 MHz

  prio_regbank #(.ADDR_W(AW), .N_SRC(NS), .N_CTX(NC), .MAX_PRIO(7),
    .PRIO_BASE(PB), .CTX_BASE(CB), .CTX_STRIDE(CS)) i_prio_regbank (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(rd_a), .src_prio_flat(sp_a),
    .ctx_thr_flat(ct_a), .upd_strobe(st_a));

  prio_regbank #(.ADDR_W(AW), .N_SRC(NS), .N_CTX(NC), .MAX_PRIO(5),
    .PRIO_BASE(PB), .CTX_BASE(CB), .CTX_STRIDE(CS)) i_prio_regbank_six (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(rd_b), .src_prio_flat(sp_b),
    .ctx_thr_flat(ct_b), .upd_strobe(st_b));

  task automatic check(input string req, input string what,
                       input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [NS*PW-1:0] pack_src(input bit b);
    logic [NS*PW-1:0] v = '0;
    for (int s = 1; s <= NS; s++) v[(s-1)*PW +: PW] = PW'(b ? m_src_b[s] : m_src_a[s]);
    return v;
  endfunction

  function automatic logic [NC*PW-1:0] pack_ctx(input bit b);
    logic [NC*PW-1:0] v = '0;
    for (int c = 0; c < NC; c++) v[c*PW +: PW] = PW'(b ? m_ctx_b[c] : m_ctx_a[c]);
    return v;
  endfunction

  // kind: 0 source (idx = source number), 1 context, 2 unmapped
  task automatic do_write(input int addr, input longint data, input int kind,
                          input int idx, input string req);
    bit acc_a, acc_b;
    int va, vb;
    acc_a = (kind != 2);                       // 8 levels: always accepted, mod 8
    va    = int'(data % 8);
    acc_b = (kind != 2) && (data <= 5);        // 6 levels: drop above 5
    vb    = int'(data);
    if (kind == 0) begin
      if (acc_a) m_src_a[idx] = va;
      if (acc_b) m_src_b[idx] = vb;
    end else if (kind == 1) begin
      if (acc_a) m_ctx_a[idx] = va;
      if (acc_b) m_ctx_b[idx] = vb;
    end
    @(negedge clk);
    bus_addr = AW'(addr); bus_wdata = 32'(data); bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    check({req, " R6"}, "strobe pow2 cfg", longint'(st_a), longint'(acc_a));
    check({req, " R6"}, "strobe six cfg", longint'(st_b), longint'(acc_b));
    check({req, " R8"}, "src flat pow2", longint'(sp_a), longint'(pack_src(0)));
    check({req, " R8"}, "src flat six", longint'(sp_b), longint'(pack_src(1)));
    check({req, " R5"}, "ctx flat pow2", longint'(ct_a), longint'(pack_ctx(0)));
    check({req, " R5"}, "ctx flat six", longint'(ct_b), longint'(pack_ctx(1)));
    #5;  // R9: readback of the same address right after the edge
    if (kind == 0) begin
      check({req, " R2"}, "read pow2", longint'(rd_a), longint'(m_src_a[idx]));
      check({req, " R2"}, "read six", longint'(rd_b), longint'(m_src_b[idx]));
    end else if (kind == 1) begin
      check({req, " R9"}, "read pow2", longint'(rd_a), longint'(m_ctx_a[idx]));
      check({req, " R9"}, "read six", longint'(rd_b), longint'(m_ctx_b[idx]));
    end else begin
      check({req, " R7"}, "read unmapped pow2", longint'(rd_a), 0);
      check({req, " R7"}, "read unmapped six", longint'(rd_b), 0);
    end
  endtask

  task automatic read_zero(input int addr, input string req);
    @(negedge clk);
    bus_addr = AW'(addr);
    #5;
    check(req, "hole read pow2", longint'(rd_a), 0);
    check(req, "hole read six", longint'(rd_b), 0);
  endtask

  initial begin
    #3_000_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    longint vals [] = '{0, 1, 5, 6, 7, 8, 9, 13, 15, 16, 'h7fff_fffd, 'hffff_ffff, 3};
    for (int s = 0; s <= NS; s++) begin m_src_a[s] = 0; m_src_b[s] = 0; end
    for (int c = 0; c < NC; c++) begin m_ctx_a[c] = 0; m_ctx_b[c] = 0; end
    rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_we = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "src pow2", longint'(sp_a), 0);
    check("R1", "src six", longint'(sp_b), 0);
    check("R1", "ctx pow2", longint'(ct_a), 0);
    check("R1", "strobe", longint'(st_a | st_b), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", "after release src", longint'(sp_a | sp_b), 0);
    check("R1", "after release ctx", longint'(ct_a | ct_b), 0);

    // R2/R3/R4: sweep every source over in-range and out-of-range values
    for (int s = 1; s <= NS; s++)
      foreach (vals[j]) do_write(PB + 4*(s-1) + (j % 4), vals[j], 0, s, "R3 R4 src");

    // R5: thresholds share the rule
    for (int c = 0; c < NC; c++)
      foreach (vals[j]) do_write(CB + c*CS, vals[j], 1, c, "R5 thr");

    // R7: writes and reads where no register lives
    do_write(PB - 4, 4, 2, 0, "R7 below prio");
    do_write(PB + 4*NS, 2, 2, 0, "R7 past prio");
    do_write(CB + 4, 1, 2, 0, "R7 ctx word1");
    do_write(CB + CS - 4, 5, 2, 0, "R7 ctx last word");
    do_write(CB + NC*CS, 3, 2, 0, "R7 past ctx");
    read_zero(0, "R7");
    read_zero(CB + CS + 8, "R7");
    read_zero(CB - 4, "R7");

    // R2: final readback of all sources
    for (int s = 1; s <= NS; s++) begin
      @(negedge clk);
      bus_addr = AW'(PB + 4*(s-1));
      #5;
      check("R2", "final pow2", longint'(rd_a), longint'(m_src_a[s]));
      check("R2", "final six", longint'(rd_b), longint'(m_src_b[s]));
    end
    @(negedge clk);
    check("R6", "idle strobe", longint'(st_a | st_b), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule